// File: doc/BRIEF.md
# Processor Sideband Control Generator

This block produces two active-low legacy control outputs for a processor. All of its logic runs on the PCI clock. The first output is the address-bit-20 mask. It is low only when a fast-gate bit held in a small system control register is clear and a keyboard-controller gate input is also clear. That gate input is resynchronised through a two-flop chain before it is combined with the register bit. The register answers a simple write port at I/O address 0x92 and shows its contents on a read-back bus.

The second output is the processor init line. Any bit of a request vector starts a low pulse lasting a fixed number of PCI clocks, 16 by default. The pulse counter stands still in every clock where the clock-stop input is high. A request that comes in while clock-stop is high is held as pending, and the pulse starts only once clock-stop falls. A request that arrives while a pulse is running is absorbed into that pulse.

No port carries a data stream, so the block has no valid/ready handshake. The write port is a one-cycle strobe and is always accepted. Every other pin is a plain level or a single-cycle pulse.

Top module: `cpu_sideband_ctl`

## Requirements
- R1: `a20_mask_n` is 0 exactly when the fast-gate bit is 0 and the synchronised gate input is 0. In every other case it is 1.
- R2: A change on `kbc_gate` reaches `a20_mask_n` after two rising clock edges.
- R3: The fast-gate bit is bit 1 of the register at address 0x92 and resets to 0. A write with `wr_en` high and `wr_addr` equal to 0x92 loads `wr_data[1]`, and `rd_data` shows the bit in position 1 with every other bit 0. A write to any other address leaves the bit unchanged.
- R4: When any bit of `init_req` is high at a clock edge and clock-stop is low, `init_n` goes low after that edge. It stays low for exactly 16 clocks when clock-stop stays low throughout.
- R5: While a pulse is running, each clock with `clk_stop` high adds one clock to the low time. The counter does not advance in that clock.
- R6: A request seen while `clk_stop` is high does not drive `init_n` low. It is held as pending, even if it lasts only one clock. The pulse then starts at the first edge where `clk_stop` is low.
- R7: A request that arrives while a pulse is running neither restarts nor lengthens it.
- R8: Synchronous reset clears the counter, any pending request, the register bit and the synchronizer. After reset `init_n` is 1 and `a20_mask_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | System control register read-back |
| kbc_gate | input | 1 | Asynchronous gate from keyboard controller |
| init_req | input | 4 | Init request pulses, OR-ed together |
| clk_stop | input | 1 | Clock-stop output level; freezes init counter |
| a20_mask_n | output | 1 | Address-bit-20 mask, active low |
| init_n | output | 1 | Processor init, active low |

## Verification
A register write shows on `rd_data` and `a20_mask_n` right after the edge that samples it. A gate change needs two edges. An init request drops `init_n` after one edge, unless clock-stop holds it back. The bench drives inputs on the falling edge and advances a reference model at each rising edge. It compares both outputs and the read-back with that model at the next falling edge, so each result is sampled in the cycle it is due. Directed runs also count the low cycles of whole pulses, both with and without clock-stop gaps.

// File: rtl/sb_pkg.sv
package sb_pkg;
  function automatic int cnt_width(input int len);
    int w;
    w = 1;
    while ((1 << w) <= len) w++;
    return w;
  endfunction
endpackage

// File: rtl/sb_gate_sync.sv
module sb_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];

  p_sync_shift_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chain[0] == $past(d_in));
endmodule

// File: rtl/sb_ctrl_reg.sv
module sb_ctrl_reg #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0092,
  parameter int          GATE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              fast_gate
);
  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_W'(PORT_ADDR));

  always_ff @(posedge clk) begin
    if (rst)      fast_gate <= 1'b0;
    else if (hit) fast_gate <= wr_data[GATE_BIT];
  end

  always_comb begin
    rd_data           = '0;
    rd_data[GATE_BIT] = fast_gate;
  end

  p_reg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(fast_gate));
  p_reg_load_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> fast_gate == $past(wr_data[GATE_BIT]));
endmodule

// File: rtl/sb_init_pulse.sv
module sb_init_pulse
  import sb_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic               clk_stop,
  output logic               init_n
);
  localparam int CW = cnt_width(PULSE_LEN);

  logic [CW-1:0] remain;
  logic          pending;
  logic          any_req;
  logic          busy;

  assign any_req = |req;
  assign busy    = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      pending <= 1'b0;
    end else if (busy) begin
      if (!clk_stop) remain <= remain - 1'b1;
    end else if (clk_stop) begin
      if (any_req) pending <= 1'b1;
    end else if (any_req || pending) begin
      remain  <= CW'(PULSE_LEN);
      pending <= 1'b0;
    end
  end

  assign init_n = !busy;

  p_hold_in_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && clk_stop) |=> remain == $past(remain));
  p_no_start_in_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && clk_stop) |=> !busy);
  p_load_full_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clk_stop && any_req) |=> remain == CW'(PULSE_LEN));
  p_merge_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !clk_stop) |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/cpu_sideband_ctl.sv
module cpu_sideband_ctl #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] PORT_ADDR   = 16'h0092,
  parameter int          GATE_BIT    = 1,
  parameter int          SYNC_STAGES = 2,
  parameter int          NUM_REQ     = 4,
  parameter int          PULSE_LEN   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               kbc_gate,
  input  logic [NUM_REQ-1:0] init_req,
  input  logic               clk_stop,
  output logic               a20_mask_n,
  output logic               init_n
);
  logic fast_gate;
  logic gate_sync;

  sb_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
                .GATE_BIT(GATE_BIT)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .fast_gate(fast_gate));

  sb_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(kbc_gate), .q_out(gate_sync));

  sb_init_pulse #(.NUM_REQ(NUM_REQ), .PULSE_LEN(PULSE_LEN)) u_init (
    .clk(clk), .rst(rst), .req(init_req), .clk_stop(clk_stop),
    .init_n(init_n));

  // R1: mask is active only when neither source opens the gate
  assign a20_mask_n = fast_gate | gate_sync;

  p_mask_follows_reg_r1: assert property (@(posedge clk) disable iff (rst)
    rd_data[GATE_BIT] |-> a20_mask_n);
endmodule

// File: tb/cpu_sideband_ctl_tb.sv
module cpu_sideband_ctl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        kbc_gate;
  logic [3:0]  init_req;
  logic        clk_stop;
  logic        a20_mask_n;
  logic        init_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_cnt;
  bit m_pend, m_s1, m_s2, m_bit;

  always #2.5 clk = ~clk;

  cpu_sideband_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .kbc_gate(kbc_gate),
    .init_req(init_req), .clk_stop(clk_stop), .a20_mask_n(a20_mask_n),
    .init_n(init_n));

  function automatic bit exp_mask_n(bit b, bit g);
    return b | g;
  endfunction

  function automatic bit exp_init_n(int c);
    return (c == 0);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_bit = 0;
      return;
    end
    m_s2 = m_s1;
    m_s1 = kbc_gate;
    if (wr_en && wr_addr == 16'h0092) m_bit = wr_data[1];
    if (m_cnt != 0) begin
      if (!clk_stop) m_cnt--;
    end else if (clk_stop) begin
      if (|init_req) m_pend = 1;
    end else if ((|init_req) || m_pend) begin
      m_cnt = 16; m_pend = 0;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1/R2 mask", 8'(a20_mask_n), 8'(exp_mask_n(m_bit, m_s2)));
    chk("R4-R7 init", 8'(init_n), 8'(exp_init_n(m_cnt)));
    chk("R3 readback", rd_data, {6'b0, m_bit, 1'b0});
    wr_en = 0; init_req = 0;
  endtask

  task automatic measure_low(string req, int expect_len, int stop_at, int stop_len);
    int low = 0;
    init_req = 4'b0100;
    cyc();
    while (!init_n && low < 100) begin
      low++;
      clk_stop = (low >= stop_at && low < stop_at + stop_len);
      cyc();
    end
    clk_stop = 0;
    chk(req, 8'(low), 8'(expect_len));
  endtask

  initial begin
    #(5 * 200000);
    $display("FAIL watchdog: actual hung expected done");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; kbc_gate = 0;
    init_req = 0; clk_stop = 0;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R8: reset state
    chk("R8 init_n", 8'(init_n), 8'd1);
    chk("R8 mask", 8'(a20_mask_n), 8'd0);

    // R3: write elsewhere ignored, then write 0x92
    wr_en = 1; wr_addr = 16'h0093; wr_data = 8'hFF; cyc();
    chk("R3 ignore", rd_data, 8'h00);
    wr_en = 1; wr_addr = 16'h0092; wr_data = 8'h02; cyc();
    chk("R3 load", rd_data, 8'h02);
    chk("R1 reg opens", 8'(a20_mask_n), 8'd1);
    wr_en = 1; wr_addr = 16'h0092; wr_data = 8'hFD; cyc();

    // R2: gate latency of two edges
    kbc_gate = 1; cyc();
    chk("R2 one edge", 8'(a20_mask_n), 8'd0);
    cyc();
    chk("R2 two edges", 8'(a20_mask_n), 8'd1);
    kbc_gate = 0; cyc(); cyc();

    // R4: plain pulse length
    measure_low("R4 length", 16, 1000, 0);
    // R5: stop for 5 clocks in the middle
    measure_low("R5 stretched", 21, 6, 5);
    // R7: extra request mid-pulse
    init_req = 4'b0001; cyc();
    repeat (8) cyc();
    init_req = 4'b1000; cyc();
    repeat (10) cyc();
    chk("R7 no extend", 8'(init_n), 8'd1);
    // R6: one-clock request during stop is pending
    clk_stop = 1; init_req = 4'b0010; cyc();
    repeat (3) begin clk_stop = 1; cyc(); end
    chk("R6 held off", 8'(init_n), 8'd1);
    clk_stop = 0; cyc();
    chk("R6 starts", 8'(init_n), 8'd0);
    repeat (20) cyc();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      kbc_gate = $urandom_range(0, 7) == 0 ? ~kbc_gate : kbc_gate;
      clk_stop = $urandom_range(0, 5) == 0;
      init_req = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'b0;
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1;
        wr_addr = $urandom_range(0, 1) ? 16'h0092 : 16'($urandom);
        wr_data = 8'($urandom);
      end
      cyc();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule